// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page-to-frame mappings, placed in front of a paged address translator. Every lookup presents a page number together with the identifier of the running address space. All slots are compared against that pair at the same time, and a matching slot returns its frame number combinationally, in the cycle of the request. When nothing matches, the block raises a miss. The caller then fetches the mapping from the in-memory page table and writes it back with a fill.

Each slot carries an address-space tag as well as its page tag, so mappings that belong to different processes can stay resident together. A context switch therefore needs no flush. Two kinds of invalidation are provided: one clears the whole cache, and the other clears only the slots owned by a single address space. Two saturating counters record lookup hits and lookup misses, so the observed hit ratio can be read out.

Top module: `xc_tlb`

## Requirements
- R1: While `lk_valid` is high, `hit` rises in the same cycle when a valid slot holds both `lk_page` and `cur_asid`, and `frame_out` then equals that slot's frame. A lookup always sees the contents from before any fill or flush in the same cycle.
- R2: A valid slot whose page tag matches but whose address-space tag differs from `cur_asid` gives a miss.
- R3: When `lk_valid` is high and no slot matches, `miss` is high and `hit` is low. When `lk_valid` is low, both are low. `frame_out` is 0 whenever `hit` is low.
- R4: A fill writes page, address space and frame into one slot on the clock edge, and a lookup of that pair hits from the next cycle on.
- R5: Slots are numbered 0 to 7. A fill with no existing match goes to the lowest-numbered invalid slot.
- R6: When all 8 slots are valid, a fill with no match replaces the slot selected by a rotating pointer. The pointer is 0 after reset and moves to the next slot (7 wraps to 0) after each such replacement only.
- R7: A fill whose page and address space match a valid slot rewrites that slot's frame and occupies no other slot.
- R8: `flush_all` invalidates every slot in one cycle.
- R9: `flush_asid_en` invalidates, in one cycle, exactly the slots whose address-space tag equals `flush_asid`. All other slots stay valid.
- R10: Priority is `flush_all` first, then `flush_asid_en`, then `fill_en`. A fill requested in a cycle with either flush is dropped.
- R11: `hit_count` and `miss_count` each increase by one per lookup cycle with a hit or a miss, respectively. Each stops at 65535. Flushes do not change them.
- R12: After reset, all slots are invalid and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_page | input | 6 | Page number to translate |
| cur_asid | input | 4 | Identifier of the running address space |
| hit | output | 1 | Lookup found a mapping |
| miss | output | 1 | Lookup found no mapping |
| frame_out | output | 6 | Frame number on a hit, else 0 |
| fill_en | input | 1 | Install a mapping |
| fill_page | input | 6 | Page number to install |
| fill_asid | input | 4 | Address-space tag to install |
| fill_frame | input | 6 | Frame number to install |
| flush_all | input | 1 | Invalidate all slots |
| flush_asid_en | input | 1 | Invalidate the slots of one address space |
| flush_asid | input | 4 | Address space to invalidate |
| hit_count | output | 16 | Saturating hit counter |
| miss_count | output | 16 | Saturating miss counter |

## Verification
The assertions rely on the fill logic never leaving two valid slots with the same page and address-space pair. They also assume that the flush and fill controls are ordinary single-cycle levels, with no meaning attached to holding them. The stimulus raises at most one control per task, apart from the deliberate fill-with-flush collisions. It also rewrites a resident pair only through an ordinary fill, which is exactly the case that the overwrite rule covers.

// File: rtl/xc_pkg.sv
// Shared definitions for the translation cache.
// Assumes: none; holds default sizes and the fill-source encoding.
package xc_pkg;
    localparam int SLOTS_DEF  = 8;
    localparam int PAGE_W_DEF = 6;
    localparam int ASID_W_DEF = 4;
    localparam int FRAME_W_DEF = 6;
    localparam int CNT_W_DEF  = 16;

    // Where a fill lands: an existing match, a free slot, or an eviction.
    typedef enum logic [1:0] {
        FILL_SAME  = 2'd0,
        FILL_FREE  = 2'd1,
        FILL_EVICT = 2'd2
    } fill_src_e;
endpackage

// File: rtl/xc_match.sv
// Parallel tag comparator: one equality check per slot on page and ASID.
// Assumes: the caller qualifies the result with its own request strobe.
module xc_match #(
    parameter int N  = 8,
    parameter int PW = 6,
    parameter int AW = 4
) (
    input  logic [N-1:0]         ent_valid,
    input  logic [N-1:0][PW-1:0] ent_page,
    input  logic [N-1:0][AW-1:0] ent_asid,
    input  logic [PW-1:0]        key_page,
    input  logic [AW-1:0]        key_asid,
    output logic [N-1:0]         match_vec
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        // One comparator per slot, all evaluated together.
        assign match_vec[i] = ent_valid[i] && (ent_page[i] == key_page)
                              && (ent_asid[i] == key_asid);
    end
endmodule

// File: rtl/xc_victim.sv
// Fill slot selection: existing match first, then lowest free, then pointer.
// Assumes: at most one bit of same_vec is set.
module xc_victim #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]      ent_valid,
    input  logic [N-1:0]      same_vec,
    input  logic [IW-1:0]     rr_ptr,
    output logic [IW-1:0]     slot,
    output xc_pkg::fill_src_e src
);
    // Scan from the top so the lowest index wins; a match overrides a free slot.
    always_comb begin
        slot = rr_ptr;
        src  = xc_pkg::FILL_EVICT;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                slot = IW'(i);
                src  = xc_pkg::FILL_FREE;
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (same_vec[i]) begin
                slot = IW'(i);
                src  = xc_pkg::FILL_SAME;
            end
        end
    end
endmodule

// File: rtl/xc_satcnt.sv
// Saturating event counter.
// Assumes: bump is a single-cycle qualified event.
module xc_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] value
);
    // Count up on each event and hold at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                  value <= '0;
        else if (bump && value != '1) value <= value + W'(1);
    end
endmodule

// File: rtl/xc_tlb.sv
// Address-space-tagged fully associative translation cache.
// Assumes: the caller walks the page table on a miss and returns the result
// with fill_en; flushes take priority over a fill in the same cycle.
module xc_tlb #(
    parameter int N       = xc_pkg::SLOTS_DEF,
    parameter int PAGE_W  = xc_pkg::PAGE_W_DEF,
    parameter int ASID_W  = xc_pkg::ASID_W_DEF,
    parameter int FRAME_W = xc_pkg::FRAME_W_DEF,
    parameter int CNT_W   = xc_pkg::CNT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [PAGE_W-1:0]  lk_page,
    input  logic [ASID_W-1:0]  cur_asid,
    output logic               hit,
    output logic               miss,
    output logic [FRAME_W-1:0] frame_out,
    input  logic               fill_en,
    input  logic [PAGE_W-1:0]  fill_page,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               flush_all,
    input  logic               flush_asid_en,
    input  logic [ASID_W-1:0]  flush_asid,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   miss_count
);
    localparam int IW = $clog2(N);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [N-1:0]              ent_valid;
    logic [N-1:0][PAGE_W-1:0]  ent_page;
    logic [N-1:0][ASID_W-1:0]  ent_asid;
    logic [N-1:0][FRAME_W-1:0] ent_frame;
    logic [IW-1:0]             rr_ptr;

    logic [N-1:0]              lk_match;
    logic [N-1:0]              fill_match;
    logic [IW-1:0]             fill_slot;
    xc_pkg::fill_src_e         fill_src;
    logic [FRAME_W-1:0]        sel_frame;

    xc_match #(.N(N), .PW(PAGE_W), .AW(ASID_W)) u_lk_cmp (
        .ent_valid (ent_valid), .ent_page (ent_page), .ent_asid (ent_asid),
        .key_page  (lk_page),   .key_asid (cur_asid), .match_vec (lk_match)
    );

    xc_match #(.N(N), .PW(PAGE_W), .AW(ASID_W)) u_fill_cmp (
        .ent_valid (ent_valid), .ent_page (ent_page), .ent_asid (ent_asid),
        .key_page  (fill_page), .key_asid (fill_asid), .match_vec (fill_match)
    );

    xc_victim #(.N(N), .IW(IW)) u_victim (
        .ent_valid (ent_valid), .same_vec (fill_match), .rr_ptr (rr_ptr),
        .slot      (fill_slot), .src      (fill_src)
    );

    // OR together the frames of matching slots; at most one is selected.
    always_comb begin
        sel_frame = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) sel_frame |= ent_frame[i];
        end
    end

    assign hit       = lk_valid && (|lk_match);
    assign miss      = lk_valid && !(|lk_match);
    assign frame_out = hit ? sel_frame : '0;

    // Valid bits and replacement pointer: reset, flushes, then fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            rr_ptr    <= '0;
        end else if (flush_all) begin
            ent_valid <= '0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < N; i++) begin
                if (ent_asid[i] == flush_asid) ent_valid[i] <= 1'b0;
            end
        end else if (fill_en) begin
            ent_valid[fill_slot] <= 1'b1;
            if (fill_src == xc_pkg::FILL_EVICT) begin
                rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + IW'(1);
            end
        end
    end

    // Slot payload: written only by a fill that no flush overrides.
    always_ff @(posedge clk) begin
        if (rst_n && fill_en && !flush_all && !flush_asid_en) begin
            ent_page[fill_slot]  <= fill_page;
            ent_asid[fill_slot]  <= fill_asid;
            ent_frame[fill_slot] <= fill_frame;
        end
    end

    xc_satcnt #(.W(CNT_W)) u_hits (
        .clk (clk), .rst_n (rst_n), .bump (hit), .value (hit_count)
    );

    xc_satcnt #(.W(CNT_W)) u_misses (
        .clk (clk), .rst_n (rst_n), .bump (miss), .value (miss_count)
    );
endmodule

// File: rtl/xc_tlb_chk.sv
// Property checker for the translation cache, bound to every xc_tlb.
// Assumes: the bind connects the slot valid bits and the lookup match vector.
module xc_tlb_chk #(
    parameter int N     = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             hit,
    input logic             miss,
    input logic             fill_en,
    input logic             flush_all,
    input logic             flush_asid_en,
    input logic [N-1:0]     ent_valid,
    input logic [N-1:0]     lk_match,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    p_result_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (hit ^ miss));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!hit && !miss));

    p_no_duplicate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all && !flush_asid_en) |=> (ent_valid != '0));

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (ent_valid == '0));

    p_hit_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_count != '1) |=> (hit_count == $past(hit_count) + CNT_W'(1)));

    p_hit_ceiling_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count == '1) |=> (hit_count == '1));

    p_miss_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !miss |=> $stable(miss_count));
endmodule

bind xc_tlb xc_tlb_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .hit           (hit),
    .miss          (miss),
    .fill_en       (fill_en),
    .flush_all     (flush_all),
    .flush_asid_en (flush_asid_en),
    .ent_valid     (ent_valid),
    .lk_match      (lk_match),
    .hit_count     (hit_count),
    .miss_count    (miss_count)
);

// File: tb/sim_xc_tlb.sv
// Bench for xc_tlb: a behavioural slot model, compared on every clock.
module sim_xc_tlb;
    localparam int N = 8;
    localparam int CMAX = 65535;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lk_valid = 1'b0;
    logic [5:0] lk_page = '0;
    logic [3:0] cur_asid = '0;
    logic       hit, miss;
    logic [5:0] frame_out;
    logic       fill_en = 1'b0;
    logic [5:0] fill_page = '0;
    logic [3:0] fill_asid = '0;
    logic [5:0] fill_frame = '0;
    logic       flush_all = 1'b0;
    logic       flush_asid_en = 1'b0;
    logic [3:0] flush_asid = '0;
    logic [15:0] hit_count, miss_count;

    always #10 clk = ~clk;

    xc_tlb u0 (
        .clk (clk), .rst_n (rst_n), .lk_valid (lk_valid), .lk_page (lk_page),
        .cur_asid (cur_asid), .hit (hit), .miss (miss), .frame_out (frame_out),
        .fill_en (fill_en), .fill_page (fill_page), .fill_asid (fill_asid),
        .fill_frame (fill_frame), .flush_all (flush_all),
        .flush_asid_en (flush_asid_en), .flush_asid (flush_asid),
        .hit_count (hit_count), .miss_count (miss_count)
    );

    int    n_checks = 0;
    int    n_fails = 0;
    string tag = "R12";
    int    m_v[N], m_p[N], m_a[N], m_f[N];
    int    m_rr = 0, m_hc = 0, m_mc = 0;

    task automatic expect_eq(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int m_find(int p, int a);
        for (int i = 0; i < N; i++)
            if (m_v[i] != 0 && m_p[i] == p && m_a[i] == a) return i;
        return -1;
    endfunction

    // Compare one cycle's outputs with the model, then advance the model.
    task automatic tick();
        int k;
        k = lk_valid ? m_find(int'(lk_page), int'(cur_asid)) : -1;
        #1;
        expect_eq("hit", int'(hit), int'(k >= 0));
        expect_eq("miss", int'(miss), int'(lk_valid && k < 0));
        expect_eq("frame", int'(frame_out), (k >= 0) ? m_f[k] : 0);
        expect_eq("hit_count", int'(hit_count), m_hc);
        expect_eq("miss_count", int'(miss_count), m_mc);
        @(posedge clk);
        if (lk_valid) begin
            if (k >= 0) begin if (m_hc < CMAX) m_hc++; end
            else if (m_mc < CMAX) m_mc++;
        end
        if (flush_all) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < N; i++) if (m_a[i] == int'(flush_asid)) m_v[i] = 0;
        end else if (fill_en) begin
            int s;
            s = m_find(int'(fill_page), int'(fill_asid));
            if (s < 0)
                for (int i = N - 1; i >= 0; i--) if (m_v[i] == 0) s = i;
            if (s < 0) begin
                s = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[s] = 1; m_p[s] = int'(fill_page);
            m_a[s] = int'(fill_asid); m_f[s] = int'(fill_frame);
        end
        @(negedge clk);
    endtask

    task automatic look(int p, int a);
        lk_valid = 1'b1; lk_page = p[5:0]; cur_asid = a[3:0];
        tick();
        lk_valid = 1'b0;
    endtask

    task automatic put(int p, int a, int f);
        fill_en = 1'b1; fill_page = p[5:0]; fill_asid = a[3:0]; fill_frame = f[5:0];
        tick();
        fill_en = 1'b0;
    endtask

    task automatic wipe();
        flush_all = 1'b1; tick(); flush_all = 1'b0;
    endtask

    task automatic wipe_asid(int a);
        flush_asid_en = 1'b1; flush_asid = a[3:0]; tick(); flush_asid_en = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (199000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_p[i] = 0; m_a[i] = 0; m_f[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        tag = "R12"; tick();
        tag = "R3";  look(5, 1); tick();
        tag = "R4";  put(5, 1, 9);
        tag = "R1";  look(5, 1);
        tag = "R2";  look(5, 2);
        tag = "R1";  lk_valid = 1'b1; lk_page = 6'd5; cur_asid = 4'd1;
        fill_en = 1'b1; fill_page = 6'd6; fill_asid = 4'd1; fill_frame = 6'd7;
        tick(); lk_valid = 1'b0; fill_en = 1'b0;
        look(6, 1);
        tag = "R5";
        for (int i = 0; i < 6; i++) put(10 + i, 1, 20 + i);
        for (int i = 0; i < 6; i++) look(10 + i, 1);
        tag = "R6";  put(30, 1, 40); look(5, 1); look(30, 1);
        put(31, 1, 41); look(6, 1); look(31, 1); look(10, 1);
        tag = "R7";  put(30, 1, 50); look(30, 1);
        for (int i = 1; i < 6; i++) look(10 + i, 1);
        look(31, 1);
        tag = "R8";  wipe(); look(30, 1); look(11, 1);
        tag = "R9";
        for (int i = 0; i < 4; i++) begin put(i, 3, i + 1); put(i, 4, i + 9); end
        wipe_asid(3);
        for (int i = 0; i < 4; i++) begin look(i, 3); look(i, 4); end
        tag = "R10";
        fill_en = 1'b1; fill_page = 6'd40; fill_asid = 4'd2; fill_frame = 6'd3;
        flush_all = 1'b1; tick(); flush_all = 1'b0; fill_en = 1'b0;
        look(40, 2); look(0, 4);
        put(41, 5, 4);
        fill_en = 1'b1; fill_page = 6'd42; fill_asid = 4'd6; fill_frame = 6'd5;
        flush_asid_en = 1'b1; flush_asid = 4'd9; tick();
        flush_asid_en = 1'b0; fill_en = 1'b0;
        look(42, 6); look(41, 5);
        tag = "R11";
        wipe();
        for (int i = 0; i < 65540; i++) look(1, 1);
        put(1, 1, 2);
        for (int i = 0; i < 65540; i++) look(1, 1);
        wipe(); tick();
        summary();
        $finish;
    end
endmodule